// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block watches system software through a kick input. A counter advances on a slow tick taken from a divided system clock. While the watchdog is enabled, if no kick arrives before the selected timeout runs out, the block raises a reset request pulse of fixed length and records the cause in a status flag.

The configuration is held in a small control register on a simple write bus. Any write may set the enable bit. Clearing the enable bit or changing the timeout code needs a two-step sequence. First comes an unlock write with both the change-enable and enable bits set. This opens a short window counted in clock cycles. The write that follows inside that window loads the new settings.

A warm (non-power-on) reset leaves the watchdog armed at its shortest timeout. While the watchdog-cause flag is set, the enable bit cannot be cleared. Software clears flags by writing zeros to the status register.

Top module: `wdog_ctrl`

## Requirements
- R1: While `por_n` is low at a clock edge, the watchdog is disabled, its code is 0, the window is closed, the power-on flag is set and the watchdog flag is cleared. After power-on, the control register reads 0x00 and the status register reads 0x01.
- R2: While `rst_n` is low and `por_n` is high at a clock edge, the enable bit is set, the code becomes 0 and the window closes. Both flags keep their values. After release, the watchdog times out at code 0 unless kicked.
- R3: Register layout, selected by `bus_addr`. With `bus_addr` 0 the control register is chosen: bit 3 is enable, bit 4 reads 1 while the change window is open, bits 2:0 hold the low three code bits and bit 5 holds code bit 3. With `bus_addr` 1 the status register is chosen: bit 0 is the power-on flag and bit 1 is the watchdog flag. All other read bits are 0.
- R4: A control write outside the window can set the enable bit. It cannot clear the enable bit and cannot change the code.
- R5: A control write with bits 4 and 3 both set, made while the window is closed, sets enable and opens the window for WIN_CYC (4) cycles. A control write made 1 to 4 cycles after the unlock loads enable and the code, then closes the window. A write made 5 or more cycles after the unlock is treated as outside the window.
- R6: Writing 0x00 inside the window disables the watchdog.
- R7: While the watchdog flag is set, a write inside the window cannot clear the enable bit, but it still loads the code.
- R8: When enabled, the request rises 2^(BASE_EXP+code) ticks after the last kick. A tick comes every TICK_DIV clocks. Measured from the last kick edge, this is between (L-1)·TICK_DIV+1 and L·TICK_DIV clocks, where L is the tick count.
- R9: Codes 10 to 15 read back as written but time out like code 9.
- R10: A kick restarts the count. While disabled, or while kicks come more often than the timeout, no request is raised.
- R11: A timeout sets the watchdog flag and raises `wdt_rst_req` for exactly PULSE_LEN cycles. Only power-on cuts the pulse short.
- R12: A status write clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low warm reset |
| por_n | input | 1 | Synchronous active-low power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects control, 1 selects status |
| bus_wdata | input | 6 | Register write data |
| bus_rdata | output | 6 | Register read data, combinational on `bus_addr` |
| kick | input | 1 | Restarts the watchdog count |
| wdt_rst_req | output | 1 | Reset request pulse |

## Verification
The assertions assume that `por_n` is asserted for at least one edge before any check matters. They also assume that bus writes are single-cycle strobes whose data is stable at the edge. The bench drives every input on the falling edge and starts with both resets low. It keeps `kick` held high during configuration sequences, so no timeout can interleave with a checked register value. Random control data is limited to the six defined bits, and the random gap after an unlock straddles the window edge.

// File: rtl/wdog_pkg.sv
// Shared constants and types for the guarded watchdog.
// Assumes a 6-bit register bus; bit positions are part of the software contract.
package wdog_pkg;
    localparam int REG_W    = 6;
    localparam int CODE_W   = 4;
    localparam int EN_BIT   = 3;
    localparam int CHG_BIT  = 4;
    localparam int P3_BIT   = 5;
    localparam int POR_BIT  = 0;
    localparam int WDT_BIT  = 1;

    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/wdog_tick_div.sv
// Slow-tick generator: one-cycle tick every TICK_DIV clocks.
// Assumes rst_n is synchronous and active low; TICK_DIV >= 1.
module wdog_tick_div #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (TICK_DIV == 1) begin : g_pass
            assign tick_o = rst_n;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] div_q;
            // Free-running divider that wraps at TICK_DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == DW'(TICK_DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign tick_o = (div_q == DW'(TICK_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/wdog_cfg.sv
// Control and status registers with the timed unlock window and cause flags.
// Assumes single-cycle write strobes; por_n dominates rst_n.
module wdog_cfg import wdog_pkg::*; #(
    parameter int WIN_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             hit_i,
    output logic             en_o,
    output code_t            code_o,
    output logic             wdt_flag_o,
    output logic [REG_W-1:0] rdata_o
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);

    logic             en_q;
    code_t            code_q;
    logic [WIN_W-1:0] win_q;
    logic             por_flag_q;
    logic             wdt_flag_q;
    logic             ctrl_wr;
    logic             stat_wr;
    logic             win_open;
    logic             unlock;

    assign ctrl_wr  = wr_i && !addr_i;
    assign stat_wr  = wr_i && addr_i;
    assign win_open = (win_q != '0);
    assign unlock   = wdata_i[CHG_BIT] && wdata_i[EN_BIT];

    // Enable, code and window: guarded loads, warm reset arms at code 0.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            en_q   <= 1'b0;
            code_q <= '0;
            win_q  <= '0;
        end else if (!rst_n) begin
            en_q   <= 1'b1;
            code_q <= '0;
            win_q  <= '0;
        end else if (ctrl_wr) begin
            if (win_open) begin
                en_q   <= wdata_i[EN_BIT] | (en_q & wdt_flag_q);
                code_q <= {wdata_i[P3_BIT], wdata_i[2:0]};
                win_q  <= '0;
            end else if (unlock) begin
                en_q   <= 1'b1;
                win_q  <= WIN_W'(WIN_CYC);
            end else begin
                en_q   <= en_q | wdata_i[EN_BIT];
            end
        end else if (win_open) begin
            win_q <= win_q - 1'b1;
        end
    end

    // Reset-cause flags: set by power-on or timeout, cleared by writing zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            por_flag_q <= 1'b1;
            wdt_flag_q <= 1'b0;
        end else begin
            if (hit_i)
                wdt_flag_q <= 1'b1;
            else if (stat_wr && !wdata_i[WDT_BIT])
                wdt_flag_q <= 1'b0;
            if (stat_wr && !wdata_i[POR_BIT])
                por_flag_q <= 1'b0;
        end
    end

    // Read mux for the two registers.
    always_comb begin
        rdata_o = '0;
        if (addr_i) begin
            rdata_o[POR_BIT] = por_flag_q;
            rdata_o[WDT_BIT] = wdt_flag_q;
        end else begin
            rdata_o[2:0]     = code_q[2:0];
            rdata_o[EN_BIT]  = en_q;
            rdata_o[CHG_BIT] = win_open;
            rdata_o[P3_BIT]  = code_q[3];
        end
    end

    assign en_o       = en_q;
    assign code_o     = code_q;
    assign wdt_flag_o = wdt_flag_q;

    // R4/R5: the code only moves through a write inside an open window.
    a_r4_code_guarded: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!$stable(code_q) && $past(rst_n) && $past(por_n)) |-> $past(ctrl_wr && win_open));

    // R5: a control write inside the window closes it.
    a_r5_window_close: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (ctrl_wr && win_open) |=> !win_open);

    // R7: enable cannot drop while the watchdog flag is set.
    a_r7_flag_lock: assert property (@(posedge clk) disable iff (!por_n)
        $past(wdt_flag_q && en_q && por_n) |-> en_q);
endmodule

// File: rtl/wdog_count.sv
// Timeout counter and reset-request pulse stretcher.
// Assumes tick_i is a one-cycle strobe; pulse is cleared only by power-on.
module wdog_count import wdog_pkg::*; #(
    parameter int BASE_EXP  = 11,
    parameter int MAX_CODE  = 9,
    parameter int PULSE_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  por_n,
    input  logic  en_i,
    input  code_t code_i,
    input  logic  kick_i,
    input  logic  tick_i,
    output logic  hit_o,
    output logic  rst_req_o
);
    localparam int CNT_W = BASE_EXP + MAX_CODE + 1;
    localparam int PW    = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [PW-1:0]    pulse_q;
    code_t            code_eff;
    logic             term;

    assign code_eff = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
    assign limit    = CNT_W'(1) << (BASE_EXP + int'(code_eff));
    assign term     = en_i && !kick_i && tick_i && (cnt_q == limit - CNT_W'(1));
    assign hit_o    = term;

    // Tick counter: kick or disable clears it, terminal count wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || kick_i)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= term ? '0 : cnt_q + 1'b1;
    end

    // Request pulse: loaded on timeout, counts down to zero.
    always_ff @(posedge clk) begin
        if (!por_n)
            pulse_q <= '0;
        else if (term)
            pulse_q <= PW'(PULSE_LEN);
        else if (pulse_q != '0)
            pulse_q <= pulse_q - 1'b1;
    end

    assign rst_req_o = (pulse_q != '0);

    // R10: a kick at an edge prevents a request from starting there.
    a_r10_kick_blocks: assert property (@(posedge clk) disable iff (!por_n)
        kick_i |=> !$rose(rst_req_o));

    // R10: a disabled watchdog never starts a request.
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n)
        !en_i |=> !$rose(rst_req_o));
endmodule

// File: rtl/wdog_ctrl.sv
// Guarded watchdog top: tick divider, register block and timeout counter.
// Assumes both resets are synchronous, active low, and por_n wins over rst_n.
module wdog_ctrl import wdog_pkg::*; #(
    parameter int TICK_DIV  = 4,
    parameter int BASE_EXP  = 11,
    parameter int MAX_CODE  = 9,
    parameter int WIN_CYC   = 4,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             kick,
    output logic             wdt_rst_req
);
    logic  any_rst_n;
    logic  tick;
    logic  en;
    logic  hit;
    logic  wdt_flag;
    code_t code;

    assign any_rst_n = rst_n && por_n;

    wdog_tick_div #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (any_rst_n),
        .tick_o (tick)
    );

    wdog_cfg #(.WIN_CYC(WIN_CYC)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_n      (por_n),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .hit_i      (hit),
        .en_o       (en),
        .code_o     (code),
        .wdt_flag_o (wdt_flag),
        .rdata_o    (bus_rdata)
    );

    wdog_count #(
        .BASE_EXP  (BASE_EXP),
        .MAX_CODE  (MAX_CODE),
        .PULSE_LEN (PULSE_LEN)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (any_rst_n),
        .por_n     (por_n),
        .en_i      (en),
        .code_i    (code),
        .kick_i    (kick),
        .tick_i    (tick),
        .hit_o     (hit),
        .rst_req_o (wdt_rst_req)
    );

    // R11: a request starts only together with the watchdog flag.
    a_r11_flag_with_req: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wdt_rst_req) |-> wdt_flag);
endmodule

// File: tb/wdog_ctrl_tb_top.sv
`timescale 1ns/1ps
module wdog_ctrl_tb_top;
    localparam int TB_DIV   = 2;
    localparam int TB_BASE  = 4;
    localparam int TB_MAX   = 9;
    localparam int TB_WIN   = 4;
    localparam int TB_PULSE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [5:0] bus_wdata = '0;
    logic [5:0] bus_rdata;
    logic       kick = 1'b0;
    logic       wdt_rst_req;

    int checks = 0;
    int fails = 0;
    int rises = 0;
    logic req_prev = 1'b0;

    // bench model of the register state
    logic       m_en = 1'b0;
    logic [3:0] m_code = '0;
    int         m_win = 0;
    logic       m_wdt = 1'b0;

    always #2.5 clk = ~clk;

    wdog_ctrl #(
        .TICK_DIV(TB_DIV), .BASE_EXP(TB_BASE), .MAX_CODE(TB_MAX),
        .WIN_CYC(TB_WIN), .PULSE_LEN(TB_PULSE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kick(kick), .wdt_rst_req(wdt_rst_req)
    );

    always @(negedge clk) begin
        if (wdt_rst_req && !req_prev) rises++;
        req_prev = wdt_rst_req;
    end

    function automatic logic [5:0] mk(input logic en, input logic chg, input logic [3:0] c);
        return {c[3], chg, en, c[2:0]};
    endfunction

    function automatic int eff(input logic [3:0] c);
        return (int'(c) > TB_MAX) ? TB_MAX : int'(c);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_win > 0) m_win--;
        end
    endtask

    task automatic wr_ctrl(input logic [5:0] d);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (m_win > 0) begin
            m_en = d[3] | (m_en & m_wdt);
            m_code = {d[5], d[2:0]};
            m_win = 0;
        end else if (d[4] && d[3]) begin
            m_en = 1'b1;
            m_win = TB_WIN;
        end else begin
            m_en = m_en | d[3];
        end
    endtask

    task automatic wr_stat(input logic [5:0] d);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (m_win > 0) m_win--;
        if (!d[1]) m_wdt = 1'b0;
    endtask

    task automatic check_ctrl(input string req);
        int v;
        rd(1'b0, v);
        check(req, v, int'(mk(m_en, m_win > 0, m_code)));
    endtask

    task automatic unlock_load(input logic [5:0] d);
        wr_ctrl(6'h18);
        wr_ctrl(d);
    endtask

    // Release kick, time the request, then time the pulse (R8, R9, R11).
    task automatic measure(input logic [3:0] c, input string req);
        int lim, n, w, v;
        bit seen;
        lim = 1 << (TB_BASE + eff(c));
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        n = 0; seen = 0;
        while (!seen && n < lim * TB_DIV + 8) begin
            @(negedge clk);
            n++;
            if (wdt_rst_req) seen = 1;
        end
        kick = 1'b1;
        if (seen && n >= (lim - 1) * TB_DIV + 1 && n <= lim * TB_DIV)
            check(req, n, n);
        else
            check(req, n, lim * TB_DIV);
        w = 0;
        while (wdt_rst_req && w < 64) begin
            w++;
            @(negedge clk);
        end
        check("R11 pulse length", w, TB_PULSE);
        rd(1'b1, v);
        check("R11 watchdog flag set", v & 2, 2);
        m_wdt = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, r0, g;
        logic [5:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R1: power-on state and R3 layout
        rd(1'b0, v); check("R1 ctrl after power-on", v, 0);
        rd(1'b1, v); check("R1 status after power-on", v, 1);

        // R10: disabled watchdog stays quiet
        r0 = rises;
        idle(2000);
        check("R10 disabled no request", rises, r0);

        // R4: code change outside window ignored
        wr_ctrl(6'h05); check_ctrl("R4 code write ignored");
        // R12: ones keep flags, zeros clear them
        wr_stat(6'h03); rd(1'b1, v); check("R12 write ones keeps flag", v, 1);
        wr_stat(6'h00); rd(1'b1, v); check("R12 write zero clears", v, 0);

        kick = 1'b1;
        // R4: enable may be set by a plain write; code stays
        wr_ctrl(6'h0E); check_ctrl("R4 plain enable");
        rd(1'b0, v); check("R4 plain enable value", v, 6'h08);

        // R5: unlock opens the window, write at 4th cycle accepted
        wr_ctrl(6'h18); check_ctrl("R5 window open after unlock");
        idle(3); wr_ctrl(6'h0B); check_ctrl("R5 last window cycle");
        rd(1'b0, v); check("R5 last window cycle value", v, 6'h0B);
        // R5: write at 5th cycle ignored
        wr_ctrl(6'h18); idle(4); wr_ctrl(6'h0D);
        rd(1'b0, v); check("R5 late write ignored", v, 6'h0B);

        // R4: plain clear ignored; R6: disable sequence
        wr_ctrl(6'h00); rd(1'b0, v); check("R4 plain clear ignored", v, 6'h0B);
        unlock_load(6'h00); rd(1'b0, v); check("R6 disable", v, 0);

        // R4/R5: random writes around the window against the model
        for (int i = 0; i < 150; i++) begin
            d = 6'($urandom());
            if ($urandom() % 2 == 0) begin
                wr_ctrl(6'h18);
                check_ctrl("R5 random unlock");
                g = int'($urandom() % 6);
                idle(g);
            end
            wr_ctrl(d);
            check_ctrl("R4 random write");
        end

        // R8/R9: timeout lengths
        unlock_load(mk(1'b1, 1'b0, 4'd0)); measure(4'd0, "R8 code 0 timeout");
        for (int i = 0; i < 3; i++) begin
            logic [3:0] c;
            c = 4'(1 + $urandom() % 5);
            unlock_load(mk(1'b1, 1'b0, c)); measure(c, "R8 random code timeout");
        end
        unlock_load(mk(1'b1, 1'b0, 4'd9)); measure(4'd9, "R8 code 9 timeout");
        unlock_load(mk(1'b1, 1'b0, 4'd12));
        rd(1'b0, v); check("R9 code 12 reads back", v, int'(mk(1'b1, 1'b0, 4'd12)));
        measure(4'd12, "R9 code 12 clamps to 9");

        // R7: flag set blocks disable but code loads
        unlock_load(6'h00); rd(1'b0, v); check("R7 enable held by flag", v, 6'h08);

        // R2: warm reset arms at code 0, keeps flags
        unlock_load(mk(1'b1, 1'b0, 4'd2));
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        m_en = 1'b1; m_code = '0; m_win = 0;
        rd(1'b0, v); check("R2 warm reset config", v, 6'h08);
        rd(1'b1, v); check("R2 warm reset keeps flag", v, 2);
        measure(4'd0, "R2 armed after warm reset");

        // R12/R6: clear flag then disable works
        wr_stat(6'h00); rd(1'b1, v); check("R12 flag cleared", v, 0);
        unlock_load(6'h00); rd(1'b0, v); check("R6 disable after clear", v, 0);

        // R10: regular kicks keep request away
        unlock_load(mk(1'b1, 1'b0, 4'd0));
        r0 = rises;
        for (int i = 0; i < 20; i++) begin
            kick = 1'b1; @(negedge clk); kick = 1'b0; idle(19);
        end
        kick = 1'b1;
        #1;
        check("R10 kicks prevent request", rises, r0);

        // R1: power-on clears the watchdog flag and disables
        measure(4'd0, "R8 before power-on");
        por_n = 1'b0; idle(2); por_n = 1'b1;
        rd(1'b0, v); check("R1 ctrl after late power-on", v, 0);
        rd(1'b1, v); check("R1 status after late power-on", v, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule